// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches a vector of already synchronised general-purpose inputs and turns chosen input conditions into interrupts. Each input has four independent detection enables: rising transition, falling transition, low level and high level. Any mix of them may be active on one input. A detected condition sets a bit in a sticky state register. Software clears that bit by writing a one to it.

Software can also set state bits directly through a test register, whatever the inputs are doing. A per-bit enable register decides which state bits reach the per-bit interrupt outputs and the single combined interrupt line. The state bits latch whether or not they are enabled.

Level conditions re-assert their state bit on every clock. A clear written while the level still holds therefore has no lasting effect. Transitions are found by comparing each input with its value on the previous clock. That history is only trusted once one clock edge has passed after reset, so leaving reset never counts as a transition.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset every register reads zero and all interrupt outputs are low. Registers are selected by `busAddr`: 0 state, 1 interrupt enable, 2 test, 3 rising enable, 4 falling enable, 5 low-level enable, 6 high-level enable. The enable registers read back what was last written.
- R2: A 0-to-1 change of an input whose rising enable bit is set sets its state bit at the clock edge that follows the change. An input with no detection enabled never sets its state bit.
- R3: A 1-to-0 change of an input whose falling enable bit is set sets its state bit at the clock edge that follows the change.
- R4: An input with both rising and falling enables set latches an event on either transition.
- R5: A state bit stays set after the condition that set it has gone, until it is cleared.
- R6: Writing the state register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: While an input is low with its low-level enable set, or high with its high-level enable set, its state bit is set at every edge, so a clear written during that time leaves the bit set.
- R8: Writing 1 to a test register bit sets the matching state bit regardless of the input. The test register reads as zero.
- R9: `irqVec` is the state ANDed with the interrupt enable, and `irqAny` is high when any bit of `irqVec` is high. State bits latch even when their enable is zero.
- R10: When a detection event and a clear write hit the same state bit at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinsIn | input | WIDTH | Synchronised input vector |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register select for write and read |
| busWdata | input | WIDTH | Register write data |
| busRdata | output | WIDTH | Read data of the selected register, combinational |
| irqVec | output | WIDTH | Per-bit enabled interrupts |
| irqAny | output | 1 | OR of all enabled interrupts |

## Verification
A detection event and a software clear can reach the same state bit at the same clock edge. The bench provokes this in two ways. First, it writes a clear while a level condition holds on that bit. Second, it applies a rising transition on a bit during the very cycle a write of 1 to that bit's state is presented. In both cases the state is read back after the edge, and the bit must still be set. One cycle later, with no event present, a repeat clear must remove the bit. This shows the surviving bit came from the event and not from a dropped write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_STATE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_TEST   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RISE   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FALL   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_LOW    = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_HIGH   = 3'd6;

  // Write strobes from the control decoder to the datapath
  typedef struct packed {
    logic wrState;
    logic wrEnable;
    logic wrTest;
    logic wrRise;
    logic wrFall;
    logic wrLow;
    logic wrHigh;
  } strobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb
);
  always_comb begin
    strb          = '0;
    strb.wrState  = busWe && (busAddr == ADDR_STATE);
    strb.wrEnable = busWe && (busAddr == ADDR_ENABLE);
    strb.wrTest   = busWe && (busAddr == ADDR_TEST);
    strb.wrRise   = busWe && (busAddr == ADDR_RISE);
    strb.wrFall   = busWe && (busAddr == ADDR_FALL);
    strb.wrLow    = busWe && (busAddr == ADDR_LOW);
    strb.wrHigh   = busWe && (busAddr == ADDR_HIGH);
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinsIn,
  input  logic [WIDTH-1:0] riseEn,
  input  logic [WIDTH-1:0] fallEn,
  input  logic [WIDTH-1:0] lowEn,
  input  logic [WIDTH-1:0] highEn,
  output logic [WIDTH-1:0] evtVec
);
  logic [WIDTH-1:0] prevIn;
  logic             primed;

  // History is trusted only after one edge out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= '0;
      primed <= 1'b0;
    end else begin
      prevIn <= pinsIn;
      primed <= 1'b1;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic roseNow, fellNow;
    assign roseNow   = primed &&  pinsIn[i] && !prevIn[i];
    assign fellNow   = primed && !pinsIn[i] &&  prevIn[i];
    assign evtVec[i] = (roseNow && riseEn[i]) || (fellNow && fallEn[i]) ||
                       (!pinsIn[i] && lowEn[i]) || (pinsIn[i] && highEn[i]);
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [WIDTH-1:0]  evtVec,
  output logic [WIDTH-1:0]  riseEn,
  output logic [WIDTH-1:0]  fallEn,
  output logic [WIDTH-1:0]  lowEn,
  output logic [WIDTH-1:0]  highEn,
  output logic [WIDTH-1:0]  stateQ,
  output logic [WIDTH-1:0]  rdData,
  output logic [WIDTH-1:0]  irqVec,
  output logic              irqAny
);
  logic [WIDTH-1:0] enableQ;
  logic [WIDTH-1:0] clrMask, setMask;

  assign clrMask = strb.wrState ? wrData : '0;
  assign setMask = evtVec | (strb.wrTest ? wrData : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      riseEn  <= '0;
      fallEn  <= '0;
      lowEn   <= '0;
      highEn  <= '0;
      stateQ  <= '0;
    end else begin
      if (strb.wrEnable) enableQ <= wrData;
      if (strb.wrRise)   riseEn  <= wrData;
      if (strb.wrFall)   fallEn  <= wrData;
      if (strb.wrLow)    lowEn   <= wrData;
      if (strb.wrHigh)   highEn  <= wrData;
      // set takes priority over clear
      stateQ <= (stateQ & ~clrMask) | setMask;
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_STATE:  rdData = stateQ;
      ADDR_ENABLE: rdData = enableQ;
      ADDR_RISE:   rdData = riseEn;
      ADDR_FALL:   rdData = fallEn;
      ADDR_LOW:    rdData = lowEn;
      ADDR_HIGH:   rdData = highEn;
      default:     rdData = '0;
    endcase
  end

  assign irqVec = stateQ & enableQ;
  assign irqAny = |irqVec;
endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  pinsIn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  output logic [WIDTH-1:0]  irqVec,
  output logic              irqAny
);
  strobes_t         strb;
  logic [WIDTH-1:0] riseEn, fallEn, lowEn, highEn;
  logic [WIDTH-1:0] evtVec, stateVec;

  gpio_irq_ctrl u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_irq_detect #(.WIDTH(WIDTH)) u_det (
    .clk    (clk),
    .rstN   (rstN),
    .pinsIn (pinsIn),
    .riseEn (riseEn),
    .fallEn (fallEn),
    .lowEn  (lowEn),
    .highEn (highEn),
    .evtVec (evtVec)
  );

  gpio_irq_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdAddr (busAddr),
    .wrData (busWdata),
    .evtVec (evtVec),
    .riseEn (riseEn),
    .fallEn (fallEn),
    .lowEn  (lowEn),
    .highEn (highEn),
    .stateQ (stateVec),
    .rdData (busRdata),
    .irqVec (irqVec),
    .irqAny (irqAny)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WIDTH-1:0]  busWdata,
  input logic [WIDTH-1:0]  stateVec,
  input logic [WIDTH-1:0]  evtVec,
  input logic [WIDTH-1:0]  irqVec,
  input logic              irqAny
);
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == ADDR_STATE) |=> ((stateVec & $past(stateVec)) == $past(stateVec))); // R5

  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_STATE) |=> ((stateVec & $past(busWdata) & ~$past(evtVec)) == '0)); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stateVec & $past(evtVec)) == $past(evtVec))); // R10

  AST_TEST_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_TEST) |=> ((stateVec & $past(busWdata)) == $past(busWdata))); // R8

  AST_IRQ_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (irqVec & ~stateVec) == '0); // R9

  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (irqVec != '0)); // R9
endmodule

bind gpio_irq_detector gpio_irq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .stateVec (stateVec),
  .evtVec   (evtVec),
  .irqVec   (irqVec),
  .irqAny   (irqAny)
);

// File: tb/sim_gpio_irq_detector.sv
module sim_gpio_irq_detector;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] pinsIn = '0;
  logic         busWe = 1'b0;
  logic [2:0]   busAddr = '0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata, irqVec;
  logic         irqAny;
  int           nTests = 0;
  int           nFails = 0;

  always #5 clk = ~clk;

  gpio_irq_detector #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqVec(irqVec), .irqAny(irqAny)
  );

  typedef struct packed {
    logic [7:0] pins;
    logic       we;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] expState;
    logic [7:0] expIrq;
    int         req;
  } step_t;

  localparam int NSTEP = 21;
  localparam step_t STEPS [NSTEP] = '{
    '{8'h00, 1'b1, 3'd1, 8'hFF, 8'h00, 8'h00, 9},  // R9 enable all
    '{8'h00, 1'b1, 3'd3, 8'h11, 8'h00, 8'h00, 2},  // R2 rising on 0,4
    '{8'h00, 1'b1, 3'd4, 8'h12, 8'h00, 8'h00, 3},  // R3 falling on 1,4
    '{8'h00, 1'b1, 3'd5, 8'h0C, 8'h00, 8'h00, 7},  // R7 low on 2,3
    '{8'h00, 1'b1, 3'd6, 8'hC0, 8'h0C, 8'h0C, 7},  // R7 low level latches
    '{8'h00, 1'b1, 3'd0, 8'h0C, 8'h0C, 8'h0C, 7},  // R7 clear blocked by level
    '{8'hFF, 1'b0, 3'd0, 8'h00, 8'hDD, 8'hDD, 4},  // R4 R2 rise + high level
    '{8'hFF, 1'b1, 3'd0, 8'hFF, 8'hC0, 8'hC0, 6},  // R6 clear, high holds
    '{8'h00, 1'b0, 3'd0, 8'h00, 8'hDE, 8'hDE, 3},  // R3 R4 fall + low level
    '{8'h00, 1'b1, 3'd0, 8'hFF, 8'h0C, 8'h0C, 7},  // R7 low holds
    '{8'h00, 1'b1, 3'd2, 8'hFF, 8'hFF, 8'hFF, 8},  // R8 test sets all
    '{8'h00, 1'b1, 3'd0, 8'hFF, 8'h0C, 8'h0C, 7},  // R7
    '{8'h0C, 1'b0, 3'd0, 8'h00, 8'h0C, 8'h0C, 5},  // R5 sticky after level gone
    '{8'h0C, 1'b1, 3'd0, 8'h00, 8'h0C, 8'h0C, 6},  // R6 zero write no effect
    '{8'h0C, 1'b1, 3'd0, 8'h04, 8'h08, 8'h08, 6},  // R6 clear one bit
    '{8'h0C, 1'b1, 3'd1, 8'h00, 8'h08, 8'h00, 9},  // R9 disable all
    '{8'h0C, 1'b1, 3'd2, 8'h01, 8'h09, 8'h00, 9},  // R9 latches while disabled
    '{8'h0C, 1'b1, 3'd1, 8'h01, 8'h09, 8'h01, 9},  // R9 enable bit 0
    '{8'h0C, 1'b1, 3'd0, 8'h09, 8'h00, 8'h00, 6},  // R6
    '{8'h0D, 1'b1, 3'd0, 8'h01, 8'h01, 8'h01, 10}, // R10 rise with clear
    '{8'h0D, 1'b1, 3'd0, 8'h01, 8'h00, 8'h00, 6}   // R6 clear after event gone
  };

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    nTests++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [W-1:0] v);
    @(negedge clk);
    busWe = 1'b0;
    busAddr = a;
    #1 v = busRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values of every register and outputs
    for (int a = 0; a < 7; a++) begin
      busAddr = 3'(a);
      #1 check($sformatf("R1 reset read addr %0d", a), busRdata, '0);
    end
    check("R1 reset irqVec", irqVec, '0);
    check("R1 reset irqAny", {7'd0, irqAny}, '0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      pinsIn = STEPS[i].pins;
      busWe = STEPS[i].we;
      busAddr = STEPS[i].addr;
      busWdata = STEPS[i].wdata;
      @(negedge clk);
      busWe = 1'b0;
      busAddr = 3'd0;
      #1;
      check($sformatf("R%0d step %0d state", STEPS[i].req, i), busRdata, STEPS[i].expState);
      check($sformatf("R%0d step %0d irqVec", STEPS[i].req, i), irqVec, STEPS[i].expIrq);
      check($sformatf("R9 step %0d irqAny", i), {7'd0, irqAny}, {7'd0, STEPS[i].expIrq != 0});
    end

    // R8 test register reads zero
    readReg(3'd2, v); check("R8 test reads zero", v, 8'h00);
    // R1 enable registers read back
    readReg(3'd3, v); check("R1 rise readback", v, 8'h11);
    readReg(3'd4, v); check("R1 fall readback", v, 8'h12);
    readReg(3'd5, v); check("R1 low readback", v, 8'h0C);
    readReg(3'd6, v); check("R1 high readback", v, 8'hC0);
    readReg(3'd1, v); check("R1 enable readback", v, 8'h01);

    // R2 bit 5 has no enables: toggling never sets it
    @(negedge clk); pinsIn = 8'h2D;
    @(negedge clk); pinsIn = 8'h0D;
    readReg(3'd0, v); check("R2 unconfigured bit stays clear", v, 8'h00);

    // R1 reset mid-run with a state bit set
    @(negedge clk); busWe = 1'b1; busAddr = 3'd2; busWdata = 8'h01;
    @(negedge clk); busWe = 1'b0; busAddr = 3'd0;
    #1 check("R9 irq before reset", irqVec, 8'h01);
    rstN = 1'b0;
    #1 check("R1 state after reset", busRdata, 8'h00);
    check("R1 irqVec after reset", irqVec, 8'h00);
    @(negedge clk); rstN = 1'b1;

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule